// File: doc/BRIEF.md
# Jam-Loaded Reference and Loop Divider Pair

This block holds the two programmable dividers of a frequency synthesizer loop. The reference divider counts reference-clock enable ticks and emits a one-cycle pulse every R ticks. The loop divider counts VCO enable ticks and emits a one-cycle pulse every N ticks. Both are down-counters that reload themselves on terminal count. The two pulse trains are meant for a phase/frequency detector outside the block.

A strobe that accepts a new N value also forces both counters to reload at the same time and sends a one-cycle reset pulse to the phase detector. Both dividers then restart in step and the loop begins again from aligned edges. Ratios outside the legal ranges are clamped to the nearest legal ratio. A new R value is picked up by the reference divider at its next terminal count, while N only changes on the strobe.

Top module: `jam_divider_pair`

## Requirements
- R1: While reset is held and in the first cycle after it, `fr_pulse`, `fv_pulse` and `pd_reset` are 0.
- R2: For an R ratio from 5 to 32767, `fr_pulse` is high for exactly the one cycle after each R-th `ref_tick`, whether ticks arrive every cycle or with gaps.
- R3: With an R ratio of 1, every `ref_tick` produces an `fr_pulse` in the following cycle.
- R4: An R ratio of 2, 3 or 4 divides by 5, and an R ratio of 0 divides by 1.
- R5: For an N ratio from 40 to 65535 latched by `n_load`, `fv_pulse` is high for exactly the one cycle after each N-th `vco_tick`.
- R6: An N ratio below 40 divides by 40.
- R7: A cycle with `n_load` high reloads both counters, ignores any tick in that same cycle, and produces no pulse in the next cycle. The first pulses after it follow the R-th and N-th ticks counted from the cycle after the load, so with equal R and N and common ticks, both pulses occur in the same cycle.
- R8: `pd_reset` is high for exactly the one cycle after each cycle with `n_load` high, and at no other time.
- R9: A change of `r_value` leaves the period in progress unchanged and applies from the next terminal count or load. A change of `n_value` without `n_load` has no effect on `fv_pulse`.
- R10: `fv_pulse` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_tick | input | 1 | Reference clock enable, one count per high cycle |
| vco_tick | input | 1 | VCO enable, one count per high cycle |
| r_value | input | 15 | Reference divide ratio |
| n_value | input | 16 | Loop divide ratio, taken on `n_load` |
| n_load | input | 1 | Accept `n_value` and reload both dividers |
| fr_pulse | output | 1 | Reference divider output pulse |
| fv_pulse | output | 1 | Loop divider output pulse |
| pd_reset | output | 1 | One-cycle phase detector reset after a load |

## Verification
The bound checker tests on every cycle that pulses only follow a tick and never follow a load cycle, that `pd_reset` tracks `n_load` exactly one cycle later, and that `fv_pulse` never repeats on adjacent cycles. The exact divide periods, the clamping of illegal ratios, the two extreme ratios, the delayed take-up of a new R value, the insensitivity to `n_value` without a strobe, and the common restart of both dividers after a load depend on counting ticks. Only the bench's directed scenarios can show those.

// File: rtl/jdiv_pkg.sv
// Package: shared widths and legal-range limits for the divider pair.
// Assumes: the reference ratio allows 1 as a special value below its minimum.
package jdiv_pkg;
    localparam int REF_W_DEF   = 15;
    localparam int LOOP_W_DEF  = 16;
    localparam int REF_MIN_DEF = 5;
    localparam int LOOP_MIN_DEF = 40;
endpackage

// File: rtl/jdiv_clamp.sv
// Module: jdiv_clamp
// Maps a raw ratio onto the legal range. Values below MIN_RATIO become
// MIN_RATIO. When ALLOW_ONE is set, 1 stays legal and 0 is treated as 1.
// Assumes: MIN_RATIO fits in W bits. Purely combinational.
module jdiv_clamp #(
    parameter int W         = 16,
    parameter int MIN_RATIO = 40,
    parameter bit ALLOW_ONE = 1'b0
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] legal
);
    localparam logic [W-1:0] MIN_V = W'(MIN_RATIO);
    localparam logic [W-1:0] ONE_V = W'(1);

    generate
        if (ALLOW_ONE) begin : g_one_ok
            // Keep 1, lift 0 to 1, lift the gap below MIN_V to MIN_V.
            always_comb begin
                if (raw <= ONE_V)
                    legal = ONE_V;
                else if (raw < MIN_V)
                    legal = MIN_V;
                else
                    legal = raw;
            end
        end else begin : g_floor
            // Lift anything under MIN_V to MIN_V.
            always_comb begin
                if (raw < MIN_V)
                    legal = MIN_V;
                else
                    legal = raw;
            end
        end
    endgenerate
endmodule

// File: rtl/jdiv_count.sv
// Module: jdiv_count
// Programmable down-counter. A tick at count zero raises a registered
// one-cycle pulse and reloads ratio-1. A jam reloads ratio-1 at once,
// discards any tick in that cycle and clears the pulse.
// Assumes: ratio is never zero (the clamp guarantees this).
module jdiv_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         jam,
    input  logic [W-1:0] ratio,
    output logic         pulse
);
    logic [W-1:0] cnt;
    logic [W-1:0] reload;

    // Reload value derived from the ratio presented this cycle.
    always_comb reload = ratio - W'(1);

    // Count down on ticks, reload on terminal count or jam.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else if (jam) begin
            cnt   <= reload;
            pulse <= 1'b0;
        end else if (tick) begin
            if (cnt == '0) begin
                cnt   <= reload;
                pulse <= 1'b1;
            end else begin
                cnt   <= cnt - W'(1);
                pulse <= 1'b0;
            end
        end else begin
            pulse <= 1'b0;
        end
    end
endmodule

// File: rtl/jam_divider_pair.sv
// Module: jam_divider_pair
// Reference divider (by R) and loop divider (by N). A load strobe latches
// a new N, reloads both counters together and pulses the phase detector
// reset one cycle later, in step with the reload.
// Assumes: tick inputs are single-cycle enables synchronous to clk.
module jam_divider_pair #(
    parameter int REF_W    = jdiv_pkg::REF_W_DEF,
    parameter int LOOP_W   = jdiv_pkg::LOOP_W_DEF,
    parameter int REF_MIN  = jdiv_pkg::REF_MIN_DEF,
    parameter int LOOP_MIN = jdiv_pkg::LOOP_MIN_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              vco_tick,
    input  logic [REF_W-1:0]  r_value,
    input  logic [LOOP_W-1:0] n_value,
    input  logic              n_load,
    output logic              fr_pulse,
    output logic              fv_pulse,
    output logic              pd_reset
);
    localparam logic [LOOP_W-1:0] LOOP_RST = LOOP_W'(LOOP_MIN);

    logic [REF_W-1:0]  r_legal;
    logic [LOOP_W-1:0] n_legal;
    logic [LOOP_W-1:0] n_held;
    logic [LOOP_W-1:0] n_ratio;

    jdiv_clamp #(.W(REF_W), .MIN_RATIO(REF_MIN), .ALLOW_ONE(1'b1)) u_rclamp (
        .raw   (r_value),
        .legal (r_legal)
    );

    jdiv_clamp #(.W(LOOP_W), .MIN_RATIO(LOOP_MIN), .ALLOW_ONE(1'b0)) u_nclamp (
        .raw   (n_value),
        .legal (n_legal)
    );

    // Hold the accepted loop ratio between load strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            n_held <= LOOP_RST;
        else if (n_load)
            n_held <= n_legal;
    end

    // Loop ratio: the new value during a load, else the held one.
    always_comb n_ratio = n_load ? n_legal : n_held;

    // Phase detector reset, aligned with the counter reload.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pd_reset <= 1'b0;
        else
            pd_reset <= n_load;
    end

    jdiv_count #(.W(REF_W)) u_rdiv (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (ref_tick),
        .jam   (n_load),
        .ratio (r_legal),
        .pulse (fr_pulse)
    );

    jdiv_count #(.W(LOOP_W)) u_ndiv (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (vco_tick),
        .jam   (n_load),
        .ratio (n_ratio),
        .pulse (fv_pulse)
    );
endmodule

// File: rtl/jdiv_checker.sv
// Module: jdiv_checker
// Cycle-level properties of the divider pair, bound to its ports.
module jdiv_checker (
    input logic clk,
    input logic rst_n,
    input logic ref_tick,
    input logic vco_tick,
    input logic n_load,
    input logic fr_pulse,
    input logic fv_pulse,
    input logic pd_reset
);
    assert_fr_follows_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fr_pulse |-> $past(ref_tick));

    assert_fv_follows_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fv_pulse |-> $past(vco_tick));

    assert_quiet_after_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(n_load) |-> (!fr_pulse && !fv_pulse));

    assert_pdreset_after_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        n_load |=> pd_reset);

    assert_pdreset_only_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pd_reset |-> $past(n_load));

    assert_fv_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fv_pulse |=> !fv_pulse);
endmodule

bind jam_divider_pair jdiv_checker u_chk (.*);

// File: tb/jam_divider_pair_test.sv
module jam_divider_pair_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        vco_tick = 1'b0;
    logic [14:0] r_value = '0;
    logic [15:0] n_value = '0;
    logic        n_load = 1'b0;
    logic        fr_pulse, fv_pulse, pd_reset;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    jam_divider_pair uut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .vco_tick(vco_tick),
        .r_value(r_value), .n_value(n_value), .n_load(n_load),
        .fr_pulse(fr_pulse), .fv_pulse(fv_pulse), .pd_reset(pd_reset)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: drive inputs, pass the edge, settle past it.
    task automatic cyc(input bit r, input bit v, input bit ld);
        ref_tick = r; vco_tick = v; n_load = ld;
        @(posedge clk); #1;
    endtask

    // Load strobe with ticks present (they must be ignored).
    task automatic jam(input int r, input int n);
        r_value = 15'(r); n_value = 16'(n);
        cyc(1, 1, 1);
        chk("R8 pd_reset after load", pd_reset, 1);
        chk("R7 no fr after load", fr_pulse, 0);
        chk("R7 no fv after load", fv_pulse, 0);
        cyc(0, 0, 0);
        chk("R8 pd_reset single", pd_reset, 0);
    endtask

    // Ticks every gap cycles; returns tick index of first pulse per channel.
    task automatic measure(input bit use_r, input bit use_v, input int gap,
                           input int maxt, output int fr_at, output int fv_at);
        int t = 0;
        fr_at = 0; fv_at = 0;
        while (t < maxt && ((use_r && fr_at == 0) || (use_v && fv_at == 0))) begin
            for (int g = 1; g < gap; g++) begin
                cyc(0, 0, 0);
                if (fr_pulse && fr_at == 0) fr_at = -1;
                if (fv_pulse && fv_at == 0) fv_at = -1;
            end
            t++;
            cyc(use_r, use_v, 0);
            if (fr_pulse && fr_at == 0) fr_at = t;
            if (fv_pulse && fv_at == 0) fv_at = t;
        end
    endtask

    task automatic t_reset;
        chk("R1 fr in reset", fr_pulse, 0);
        chk("R1 fv in reset", fv_pulse, 0);
        chk("R1 pd_reset in reset", pd_reset, 0);
        rst_n = 1'b1;
        cyc(0, 0, 0);
        chk("R1 fr after reset", fr_pulse, 0);
        chk("R1 pd_reset after reset", pd_reset, 0);
    endtask

    task automatic t_ref_period;
        int a, b;
        jam(7, 40);
        measure(1, 0, 1, 100, a, b);
        chk("R2 R=7 first period", a, 7);
        measure(1, 0, 3, 100, a, b);
        chk("R2 R=7 gapped period", a, 7);
        cyc(0, 0, 0);
        chk("R2 pulse one cycle", fr_pulse, 0);
    endtask

    task automatic t_ref_one;
        int a, b;
        jam(1, 40);
        for (int i = 0; i < 3; i++) begin
            measure(1, 0, 1, 10, a, b);
            chk("R3 R=1 every tick", a, 1);
        end
        jam(0, 40);
        measure(1, 0, 2, 10, a, b);
        chk("R4 R=0 acts as 1", a, 1);
        measure(1, 0, 1, 10, a, b);
        chk("R4 R=0 acts as 1 again", a, 1);
    endtask

    task automatic t_ref_clamp;
        int a, b;
        jam(3, 40);
        measure(1, 0, 1, 50, a, b);
        chk("R4 R=3 acts as 5", a, 5);
        jam(2, 40);
        measure(1, 0, 1, 50, a, b);
        chk("R4 R=2 acts as 5", a, 5);
    endtask

    task automatic t_loop;
        int a, b;
        jam(5, 45);
        measure(0, 1, 1, 200, a, b);
        chk("R5 N=45 first period", b, 45);
        n_value = 16'd100;
        measure(0, 1, 2, 200, a, b);
        chk("R9 N change without load ignored", b, 45);
        jam(5, 10);
        measure(0, 1, 1, 200, a, b);
        chk("R6 N=10 acts as 40", b, 40);
    endtask

    task automatic t_align;
        int a, b;
        jam(50, 50);
        for (int i = 0; i < 17; i++) cyc(1, 0, 0);
        for (int i = 0; i < 23; i++) cyc(0, 1, 0);
        jam(50, 50);
        measure(1, 1, 1, 200, a, b);
        chk("R7 fr restart after load", a, 50);
        chk("R7 fv restart after load", b, 50);
    endtask

    task automatic t_rchange;
        int a, b;
        jam(6, 40);
        cyc(1, 0, 0); cyc(1, 0, 0);
        r_value = 15'd9;
        measure(1, 0, 1, 50, a, b);
        chk("R9 period in progress kept", a, 4);
        measure(1, 0, 1, 50, a, b);
        chk("R9 new R at terminal count", a, 9);
    endtask

    task automatic t_extremes;
        int a, b;
        jam(32767, 65535);
        measure(1, 1, 1, 70000, a, b);
        chk("R2 R=32767 period", a, 32767);
        chk("R5 N=65535 period", b, 65535);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        t_ref_period();
        t_ref_one();
        t_ref_clamp();
        t_loop();
        t_align();
        t_rchange();
        t_extremes();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule